// File: doc/BRIEF.md
# Serial Port Register and FIFO Front End

This block sits between a processor bus and the byte-level engines of a serial port. Software reaches it through a word-indexed register window with separate read and write strobes. The window has six slots:

- a transmit data slot;
- a receive data slot;
- a control word;
- a status word;
- an interrupt level word;
- a line speed word.

Bytes written to the transmit slot queue in a 64-entry FIFO. The FIFO hands them to a serializer over a valid/ready handshake. Bytes delivered by a deserializer, together with parity and framing error flags, queue in a second 64-entry FIFO. Software reads them back through the receive slot.

Error conditions are kept as sticky flags in the status word until software clears them. One level interrupt output combines two requests. The receive request fires when the receive FIFO holds at least a programmed number of bytes. The transmit request fires when the transmit FIFO has drained to a programmed level or below. Framing, baud generation and modem pins live outside this block. The line speed word is only stored and presented on an output for the external engines.

`bus_addr` is a word index. Index n corresponds to byte offset 4·n:

| Index | Slot |
|---|---|
| 0 | transmit data |
| 1 | receive data |
| 2 | control |
| 3 | status |
| 4 | interrupt levels |
| 5 | line speed |

The asynchronous reset is released through a two-stage synchronizer, so registers leave reset two clock edges after `rst_n` rises.

Top module: `serial_port_front`

## Requirements
- R1: After reset the status word reads 0x0050_0000, which is receive-empty (bit 20) and transmit-empty (bit 22) set and every other bit clear. The control and level words read zero, and `irq` is low.
- R2: Bytes written to index 0 (bits [7:0]) leave on `tx_data` in write order, one per cycle in which `tx_valid` and `tx_ready` are both high. `tx_valid` stays low while control bit 12 (transmit enable) is clear. `tx_data` holds steady while `tx_valid` waits for `tx_ready`.
- R3: After 64 queued bytes, status bit 21 (transmit full) is set. A further write to index 0 is discarded and sets sticky status bit 18 (transmit overflow).
- R4: `rx_ready` is high only while control bit 13 (receive enable) is set and the receive FIFO is not full. Accepted bytes are returned in arrival order by reads of index 1, in bits [7:0] with bits [31:8] zero, and each such read removes one byte.
- R5: A read of index 1 while the receive FIFO is empty returns zero and does not advance the read position.
- R6: Status bit 16 (parity error) and bit 17 (framing error) are set only when a byte carrying that flag is accepted into the receive FIFO. They stay set through later clean bytes. Bits 16–18 are cleared while control bit 24 is set.
- R7: While control bit 22 is set the transmit FIFO is emptied and held empty. While control bit 23 is set the receive FIFO is emptied and held empty.
- R8: With control bit 27 set, `irq` is high whenever the receive FIFO count is at or above level-word bits [7:0].
- R9: With control bit 28 set, `irq` is high whenever the transmit FIFO count is at or below level-word bits [15:8]. With both bits 27 and 28 clear, `irq` is low.
- R10: Status bit 25 follows the `tx_busy` input. The transmitter is idle when bit 22 is set and bit 25 is clear.
- R11: The value written to index 5 reads back in its low 25 bits and drives `baud_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; pops the receive FIFO at index 1 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed slot |
| tx_data | output | 8 | Byte offered to the serializer |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_busy | input | 1 | Serializer is shifting a byte |
| rx_data | input | 8 | Byte from the deserializer |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive byte accepted |
| rx_par_err | input | 1 | Offered byte had a parity error |
| rx_frm_err | input | 1 | Offered byte had a framing error |
| baud_cfg | output | 25 | Stored line speed word |
| irq | output | 1 | Level interrupt |

## Verification
The transmit path is driven with short bursts that are held back by the enable and then drained, and with a burst that fills the FIFO and then overflows it. Together these separate ordering faults from full-detection and overflow-flag faults. The receive path gets three kinds of input:

- ordered clean bytes, interleaved with reads of the empty slot, which shows whether an empty read moves the pointer;
- a burst up to full, to check back-pressure;
- bytes with parity or framing flags, offered both with receive disabled and enabled, which tells latching-on-accept apart from latching-on-offer and exposes stickiness and clearing.

The interrupt is stepped across its receive and transmit levels one byte at a time, so off-by-one comparisons show up.

// File: rtl/serial_front_pkg.sv
package serial_front_pkg;

  typedef enum logic [2:0] {
    REG_TXD  = 3'd0,
    REG_RXD  = 3'd1,
    REG_CTRL = 3'd2,
    REG_STAT = 3'd3,
    REG_LVL  = 3'd4,
    REG_BAUD = 3'd5
  } reg_sel_e;

  // control word bit positions
  localparam int CTL_TX_EN    = 12;
  localparam int CTL_RX_EN    = 13;
  localparam int CTL_TX_FLUSH = 22;
  localparam int CTL_RX_FLUSH = 23;
  localparam int CTL_ERR_CLR  = 24;
  localparam int CTL_RX_IE    = 27;
  localparam int CTL_TX_IE    = 28;

  // status word bit positions
  localparam int ST_PAR      = 16;
  localparam int ST_FRM      = 17;
  localparam int ST_OVF      = 18;
  localparam int ST_RX_EMPTY = 20;
  localparam int ST_TX_FULL  = 21;
  localparam int ST_TX_EMPTY = 22;
  localparam int ST_TX_BUSY  = 25;

endpackage

// File: rtl/fifo_ring.sv
module fifo_ring #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          push,
  input  logic [WIDTH-1:0]              push_data,
  input  logic                          pop,
  output logic [WIDTH-1:0]              pop_data,
  output logic [$clog2(DEPTH):0]        count,
  output logic                          full,
  output logic                          empty
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [CNT_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0] rd_ptr_q, rd_ptr_d;
  logic             do_push, do_pop;

  assign count    = wr_ptr_q - rd_ptr_q;
  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign do_push  = push & ~full & ~flush;
  assign do_pop   = pop & ~empty & ~flush;
  assign pop_data = mem[rd_ptr_q[PTR_W-1:0]];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
    end else begin
      if (do_push) wr_ptr_d = wr_ptr_q + CNT_W'(1);
      if (do_pop)  rd_ptr_d = rd_ptr_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q[PTR_W-1:0]] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !flush |=> full && $stable(wr_ptr_q)); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push && !flush |=> empty && $stable(rd_ptr_q)); // R5

endmodule

// File: rtl/sticky_err.sv
module sticky_err (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic set_par,
  input  logic set_frm,
  input  logic set_ovf,
  output logic par_flag,
  output logic frm_flag,
  output logic ovf_flag
);

  logic par_d, frm_d, ovf_d;

  always_comb begin
    if (clear) begin
      par_d = 1'b0;
      frm_d = 1'b0;
      ovf_d = 1'b0;
    end else begin
      par_d = par_flag | set_par;
      frm_d = frm_flag | set_frm;
      ovf_d = ovf_flag | set_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_flag <= 1'b0;
      frm_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      par_flag <= par_d;
      frm_flag <= frm_d;
      ovf_flag <= ovf_d;
    end
  end

  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    par_flag && !clear |=> par_flag); // R6

  AST_FRM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frm_flag && !clear |=> frm_flag); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !par_flag && !frm_flag && !ovf_flag); // R6

endmodule

// File: rtl/irq_gen.sv
module irq_gen #(
  parameter int CNT_W = 7,
  parameter int LVL_W = 8
) (
  input  logic             rx_ie,
  input  logic             tx_ie,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  output logic             irq
);

  logic rx_req, tx_req;

  assign rx_req = rx_ie & (32'(rx_count) >= 32'(rx_level));
  assign tx_req = tx_ie & (32'(tx_count) <= 32'(tx_level));
  assign irq    = rx_req | tx_req;

endmodule

// File: rtl/serial_port_front.sv
module serial_port_front
  import serial_front_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int DATA_W     = 8,
  parameter int LVL_W      = 8,
  parameter int BAUD_W     = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic              tx_busy,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  output logic [BAUD_W-1:0] baud_cfg,
  output logic              irq
);

  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  // reset: asserted at once, released through two stages
  logic [1:0] rst_pipe;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  // register decode
  reg_sel_e sel;
  logic     ctrl_we, lvl_we, baud_we, txd_wr, rxd_rd;

  assign sel     = reg_sel_e'(bus_addr);
  assign ctrl_we = bus_wr & (sel == REG_CTRL);
  assign lvl_we  = bus_wr & (sel == REG_LVL);
  assign baud_we = bus_wr & (sel == REG_BAUD);
  assign txd_wr  = bus_wr & (sel == REG_TXD);
  assign rxd_rd  = bus_rd & (sel == REG_RXD);

  logic [31:0]        ctrl_q;
  logic [2*LVL_W-1:0] lvl_q;
  logic [BAUD_W-1:0]  baud_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ctrl_q <= '0;
      lvl_q  <= '0;
      baud_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= bus_wdata;
      if (lvl_we)  lvl_q  <= bus_wdata[2*LVL_W-1:0];
      if (baud_we) baud_q <= bus_wdata[BAUD_W-1:0];
    end
  end

  assign baud_cfg = baud_q;

  // transmit queue
  logic [CNT_W-1:0]  tx_count;
  logic              tx_full, tx_empty, tx_pop;
  logic [DATA_W-1:0] tx_head;

  assign tx_valid = ctrl_q[CTL_TX_EN] & ~ctrl_q[CTL_TX_FLUSH] & ~tx_empty;
  assign tx_pop   = tx_valid & tx_ready;
  assign tx_data  = tx_head;

  fifo_ring #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (arst_n),
    .flush     (ctrl_q[CTL_TX_FLUSH]),
    .push      (txd_wr),
    .push_data (bus_wdata[DATA_W-1:0]),
    .pop       (tx_pop),
    .pop_data  (tx_head),
    .count     (tx_count),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  // receive queue
  logic [CNT_W-1:0]  rx_count;
  logic              rx_full, rx_empty, rx_push;
  logic [DATA_W-1:0] rx_head;

  assign rx_ready = ctrl_q[CTL_RX_EN] & ~ctrl_q[CTL_RX_FLUSH] & ~rx_full;
  assign rx_push  = rx_valid & rx_ready;

  fifo_ring #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (arst_n),
    .flush     (ctrl_q[CTL_RX_FLUSH]),
    .push      (rx_push),
    .push_data (rx_data),
    .pop       (rxd_rd),
    .pop_data  (rx_head),
    .count     (rx_count),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  // sticky error flags
  logic err_par, err_frm, err_ovf;

  sticky_err u_err (
    .clk      (clk),
    .rst_n    (arst_n),
    .clear    (ctrl_q[CTL_ERR_CLR]),
    .set_par  (rx_push & rx_par_err),
    .set_frm  (rx_push & rx_frm_err),
    .set_ovf  (txd_wr & tx_full),
    .par_flag (err_par),
    .frm_flag (err_frm),
    .ovf_flag (err_ovf)
  );

  // interrupt
  irq_gen #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_irq (
    .rx_ie    (ctrl_q[CTL_RX_IE]),
    .tx_ie    (ctrl_q[CTL_TX_IE]),
    .rx_count (rx_count),
    .tx_count (tx_count),
    .rx_level (lvl_q[LVL_W-1:0]),
    .tx_level (lvl_q[2*LVL_W-1:LVL_W]),
    .irq      (irq)
  );

  // status and read mux
  logic [31:0] status;

  always_comb begin
    status              = '0;
    status[ST_PAR]      = err_par;
    status[ST_FRM]      = err_frm;
    status[ST_OVF]      = err_ovf;
    status[ST_RX_EMPTY] = rx_empty;
    status[ST_TX_FULL]  = tx_full;
    status[ST_TX_EMPTY] = tx_empty;
    status[ST_TX_BUSY]  = tx_busy;
  end

  always_comb begin
    case (sel)
      REG_RXD:  bus_rdata = rx_empty ? 32'd0 : {{(32-DATA_W){1'b0}}, rx_head};
      REG_CTRL: bus_rdata = ctrl_q;
      REG_STAT: bus_rdata = status;
      REG_LVL:  bus_rdata = {{(32-2*LVL_W){1'b0}}, lvl_q};
      REG_BAUD: bus_rdata = {{(32-BAUD_W){1'b0}}, baud_q};
      default:  bus_rdata = 32'd0;
    endcase
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    tx_valid && !tx_ready && !ctrl_we |=> tx_valid && $stable(tx_data)); // R2

  AST_TX_OVF_FLAG: assert property (@(posedge clk) disable iff (!arst_n)
    txd_wr && tx_full && !ctrl_q[CTL_ERR_CLR] |=> status[ST_OVF]); // R3

  AST_RX_ACCEPT: assert property (@(posedge clk) disable iff (!arst_n)
    rx_push |=> !status[ST_RX_EMPTY]); // R4

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!arst_n)
    rxd_rd && rx_empty && !rx_push |=> status[ST_RX_EMPTY]); // R5

endmodule

// File: tb/serial_port_front_tb_top.sv
module serial_port_front_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready, tx_busy;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_ready, rx_par_err, rx_frm_err;
  logic [24:0] baud_cfg;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_port_front dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_busy(tx_busy), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
    .baud_cfg(baud_cfg), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_offer(input logic [7:0] b, input logic pe, input logic fe);
    @(negedge clk);
    rx_data = b; rx_par_err = pe; rx_frm_err = fe; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
  endtask

  task automatic tx_take(output logic [7:0] b, output logic v);
    @(negedge clk);
    v = tx_valid; b = tx_data;
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(3'd3, d); chk("R1 status", d, 32'h0050_0000);
    bus_read(3'd2, d); chk("R1 control", d, 32'h0);
    bus_read(3'd4, d); chk("R1 level", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_tx_order();
    logic [7:0] b; logic v; logic [31:0] d;
    bus_write(3'd0, 32'hFFFF_FFA5);
    bus_write(3'd0, 32'h3C);
    bus_write(3'd0, 32'h0F);
    #1 chk("R2 valid low while disabled", {31'b0, tx_valid}, 32'h0);
    bus_write(3'd2, 32'h0000_1000);
    // hold-off: valid without ready keeps the head byte
    @(negedge clk); chk("R2 head held", {24'b0, tx_data}, 32'hA5);
    tx_take(b, v); chk("R2 byte0", {23'b0, v, b}, {23'b0, 1'b1, 8'hA5});
    tx_take(b, v); chk("R2 byte1", {23'b0, v, b}, {23'b0, 1'b1, 8'h3C});
    tx_take(b, v); chk("R2 byte2", {23'b0, v, b}, {23'b0, 1'b1, 8'h0F});
    #1 chk("R2 drained", {31'b0, tx_valid}, 32'h0);
    bus_read(3'd3, d); chk("R2 empty flag", {31'b0, d[22]}, 32'h1);
    bus_write(3'd2, 32'h0);
  endtask

  task automatic t_tx_full();
    logic [31:0] d;
    for (int i = 0; i < 64; i++) bus_write(3'd0, i);
    bus_read(3'd3, d);
    chk("R3 full set", {29'b0, d[22:21], d[18]}, {29'b0, 2'b01, 1'b0});
    bus_write(3'd0, 32'hEE);
    bus_read(3'd3, d); chk("R3 overflow sticky", {31'b0, d[18]}, 32'h1);
    bus_write(3'd2, 32'h0100_0000);
    bus_write(3'd2, 32'h0);
    bus_read(3'd3, d); chk("R6 clear overflow", {31'b0, d[18]}, 32'h0);
    bus_write(3'd2, 32'h0040_0000);
    bus_write(3'd2, 32'h0000_1000);
    #1 chk("R7 tx flush valid", {31'b0, tx_valid}, 32'h0);
    bus_read(3'd3, d); chk("R7 tx flush empty", {30'b0, d[22:21]}, 32'h2);
    bus_write(3'd2, 32'h0);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    rx_offer(8'h55, 1'b0, 1'b0);
    bus_read(3'd3, d); chk("R4 disabled no accept", {31'b0, d[20]}, 32'h1);
    bus_write(3'd2, 32'h0000_2000);
    #1 chk("R4 ready", {31'b0, rx_ready}, 32'h1);
    rx_offer(8'h81, 1'b0, 1'b0);
    rx_offer(8'h42, 1'b0, 1'b0);
    rx_offer(8'hC3, 1'b0, 1'b0);
    bus_read(3'd1, d); chk("R4 rx0", d, 32'h81);
    bus_read(3'd1, d); chk("R4 rx1", d, 32'h42);
    bus_read(3'd1, d); chk("R4 rx2", d, 32'hC3);
    bus_read(3'd1, d); chk("R5 empty read zero", d, 32'h0);
    bus_read(3'd1, d); chk("R5 empty read again", d, 32'h0);
    rx_offer(8'h77, 1'b0, 1'b0);
    bus_read(3'd1, d); chk("R5 pointer unmoved", d, 32'h77);
    for (int i = 0; i < 64; i++) rx_offer(8'(i), 1'b0, 1'b0);
    #1 chk("R4 full backpressure", {31'b0, rx_ready}, 32'h0);
    bus_read(3'd1, d); chk("R4 full head", d, 32'h0);
    bus_write(3'd2, 32'h0080_2000);
    bus_write(3'd2, 32'h0000_2000);
    bus_read(3'd3, d); chk("R7 rx flush", {31'b0, d[20]}, 32'h1);
    bus_write(3'd2, 32'h0);
  endtask

  task automatic t_err();
    logic [31:0] d;
    rx_offer(8'h99, 1'b1, 1'b1);
    bus_read(3'd3, d); chk("R6 not latched when refused", {29'b0, d[18:16]}, 32'h0);
    bus_write(3'd2, 32'h0000_2000);
    rx_offer(8'h11, 1'b1, 1'b0);
    bus_read(3'd3, d); chk("R6 parity set", {29'b0, d[18:16]}, 32'h1);
    rx_offer(8'h22, 1'b0, 1'b0);
    bus_read(3'd3, d); chk("R6 parity sticky", {29'b0, d[18:16]}, 32'h1);
    rx_offer(8'h00, 1'b0, 1'b1);
    bus_read(3'd3, d); chk("R6 framing set", {29'b0, d[18:16]}, 32'h3);
    bus_read(3'd1, d); chk("R6 byte kept", d, 32'h11);
    bus_write(3'd2, 32'h0100_2000);
    bus_write(3'd2, 32'h0000_2000);
    bus_read(3'd3, d); chk("R6 cleared", {29'b0, d[18:16]}, 32'h0);
    bus_write(3'd2, 32'h0080_0000);
    bus_write(3'd2, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bus_write(3'd4, 32'h0000_0102);
    bus_write(3'd2, 32'h0800_2000);
    #1 chk("R8 below level", {31'b0, irq}, 32'h0);
    rx_offer(8'h01, 1'b0, 1'b0);
    #1 chk("R8 one below level", {31'b0, irq}, 32'h0);
    rx_offer(8'h02, 1'b0, 1'b0);
    #1 chk("R8 at level", {31'b0, irq}, 32'h1);
    bus_read(3'd1, d);
    #1 chk("R8 drops after read", {31'b0, irq}, 32'h0);
    bus_read(3'd1, d);
    bus_write(3'd2, 32'h1000_0000);
    #1 chk("R9 tx empty fires", {31'b0, irq}, 32'h1);
    bus_write(3'd0, 32'hAA);
    #1 chk("R9 at level", {31'b0, irq}, 32'h1);
    bus_write(3'd0, 32'hBB);
    #1 chk("R9 above level", {31'b0, irq}, 32'h0);
    bus_write(3'd2, 32'h0040_0000);
    bus_write(3'd2, 32'h0);
    #1 chk("R9 both disabled", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_busy_baud();
    logic [31:0] d;
    @(negedge clk); tx_busy = 1'b1;
    bus_read(3'd3, d); chk("R10 busy", {30'b0, d[25], d[22]}, 32'h3);
    @(negedge clk); tx_busy = 1'b0;
    bus_read(3'd3, d); chk("R10 idle", {30'b0, d[25], d[22]}, 32'h1);
    bus_write(3'd5, 32'hFF80_1234);
    bus_read(3'd5, d); chk("R11 readback", d, 32'h0180_1234);
    chk("R11 output", {7'b0, baud_cfg}, 32'h0180_1234);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    tx_ready = 1'b0; tx_busy = 1'b0; rx_data = '0; rx_valid = 1'b0;
    rx_par_err = 1'b0; rx_frm_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx_order();
    t_tx_full();
    t_rx();
    t_err();
    t_irq();
    t_busy_baud();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule